// File: doc/BRIEF.md
# Backplane Frame Offset Aligner

This block tracks frame position on a serial transmit backplane. One data bit and one signaling bit arrive on every clock. A frame pulse marks a reference point. The first bit of the matching frame arrives a programmable distance after that pulse. The distance is a timeslot offset times eight, plus a bit offset of 0 to 7. A position counter turns that distance into a timeslot index and a bit index for every incoming bit. It also assembles the data stream and the signaling stream into bytes. Both streams share the same timeslot boundaries.

Two frame formats are supported. In single-link mode a frame has 32 timeslots, or 256 bits. In multiplexed mode a frame has 128 timeslots, or 1024 bits, carrying four interleaved links. Each assembled byte is presented with a one-cycle valid strobe. The serial backplane cannot be stalled, so the output has no ready input and no back-pressure: the consumer must accept each byte in the cycle its strobe is high. A byte stays on the output until the next strobe. A frame pulse that arrives away from its expected position sets a sticky change flag, and the counter realigns to the new pulse.

Top module: `bfa_top`

## Requirements
- R1: During and directly after reset, `ts_idx`, `bit_idx`, `byte_valid` and `offset_change` are all 0.
- R2: In single-link mode (`mux_mode`=0), let the input bit be sampled k edges after the edge that samples `frame_pulse` high, with k=0 for that same edge. That bit has frame index (k − 8·ts_offset − bit_offset) mod 256. After that edge, `ts_idx` shows index/8 and `bit_idx` shows index mod 8.
- R3: In single-link mode only `ts_offset[4:0]` is used, so offsets 0 to 31 apply and bits 6:5 have no effect.
- R4: In multiplexed mode (`mux_mode`=1) the R2 rule applies with a frame length of 1024 and the full 7-bit `ts_offset` (0 to 127).
- R5: Without further pulses, the indices wrap from the last bit of the frame back to timeslot 0, bit 0, and keep counting.
- R6: `byte_valid` is high for exactly the cycle after the edge that samples bit 7 of a timeslot. `data_byte` then holds that timeslot's eight data bits, MSB first: bit 0 sampled is `data_byte[7]`. The byte is held until the next strobe.
- R7: `sig_byte` is assembled from `ser_sig` with the same timeslot boundaries and strobe as `data_byte`.
- R8: Before the first frame pulse after reset, `byte_valid` stays low. The first pulse never sets `offset_change`.
- R9: A later pulse that arrives exactly where the current alignment expects frame bit index (L − offset) mod L leaves `offset_change` at 0 and does not disturb counting.
- R10: A pulse at any other position sets `offset_change`, and counting realigns to that pulse per R2/R4.
- R11: `offset_change` stays 1 until reset, including through later correctly placed pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux_mode | input | 1 | 0: 32-timeslot frame, 1: 128-timeslot multiplexed frame |
| ts_offset | input | 7 | Timeslot part of the pulse-to-frame offset |
| bit_offset | input | 3 | Bit part of the pulse-to-frame offset |
| frame_pulse | input | 1 | Frame reference pulse, sampled with the current bit |
| ser_data | input | 1 | Serial payload bit |
| ser_sig | input | 1 | Serial signaling bit |
| ts_idx | output | 7 | Timeslot index of the last sampled bit |
| bit_idx | output | 3 | Bit position within the timeslot of the last sampled bit |
| byte_valid | output | 1 | One-cycle strobe for a completed timeslot byte |
| data_byte | output | 8 | Last completed payload byte, MSB first |
| sig_byte | output | 8 | Last completed signaling byte, MSB first |
| offset_change | output | 1 | Sticky flag for a frame pulse at an unexpected position |

## Verification
A wrong position count shows at once as a wrong `ts_idx` or `bit_idx` on the edge that samples the affected bit. It also moves the `byte_valid` strobe off bit 7, so the payload and signaling bytes come out rotated within the same timeslot. A faulty load value or a broken pulse-position comparison shows in the same cycle as a misaligned first frame. It can also show up to one frame later: a correctly placed second pulse then raises `offset_change` when it should not, or a shifted pulse fails to raise it. Offsets are swept across every bit position and the ends of both timeslot ranges. Each is checked over two frames, so wrap and re-pulse errors surface within 2·L cycles.

// File: rtl/bfa_pkg.sv
package bfa_pkg;
  localparam int BITS_PER_TS = 8;
  localparam int SINGLE_TS   = 32;
  localparam int MUX_TS      = 128;
  localparam int BIT_W       = $clog2(BITS_PER_TS);
  localparam int TS_W        = $clog2(MUX_TS);
  localparam int POS_W       = TS_W + BIT_W;
  localparam int SINGLE_LEN  = SINGLE_TS * BITS_PER_TS;
  localparam int MUX_LEN     = MUX_TS * BITS_PER_TS;
  typedef logic [POS_W-1:0] pos_t;
endpackage

// File: rtl/bfa_pos_counter.sv
module bfa_pos_counter
  import bfa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mux_mode,
  input  logic [TS_W-1:0]  ts_offset,
  input  logic [BIT_W-1:0] bit_offset,
  input  logic             frame_pulse,
  output pos_t             pos_eff,
  output logic             synced,
  output logic             offset_change
);
  pos_t len_mask;
  pos_t offset_bits;
  pos_t load_pos;
  pos_t pos_q;
  pos_t pos_masked;

  // The frame length is a power of two, so masking gives modulo.
  // In single-link mode the mask also drops ts_offset[6:5].
  always_comb begin
    len_mask    = mux_mode ? pos_t'(MUX_LEN - 1) : pos_t'(SINGLE_LEN - 1);
    offset_bits = {ts_offset, bit_offset} & len_mask;
    load_pos    = (pos_t'(0) - offset_bits) & len_mask;
    pos_masked  = pos_q & len_mask;
    pos_eff     = frame_pulse ? load_pos : pos_masked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q         <= '0;
      synced        <= 1'b0;
      offset_change <= 1'b0;
    end else begin
      pos_q <= (pos_eff + pos_t'(1)) & len_mask;
      if (frame_pulse) begin
        synced <= 1'b1;
        if (synced && (pos_masked != load_pos)) offset_change <= 1'b1;
      end
    end
  end

  p_sticky_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    offset_change |=> offset_change);

  p_first_pulse_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_pulse && !synced) |=> !offset_change);

  p_sync_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    synced |=> synced);
endmodule

// File: rtl/bfa_byte_asm.sv
module bfa_byte_asm
  import bfa_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [LANES-1:0]                    ser_in,
  input  logic                                last_bit,
  input  logic                                aligned,
  output logic [LANES-1:0][BITS_PER_TS-1:0]   bytes_out,
  output logic                                byte_valid
);
  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      logic [BITS_PER_TS-2:0] shreg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          shreg        <= '0;
          bytes_out[g] <= '0;
        end else begin
          shreg <= {shreg[BITS_PER_TS-3:0], ser_in[g]};
          if (last_bit) bytes_out[g] <= {shreg, ser_in[g]};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byte_valid <= 1'b0;
    else        byte_valid <= last_bit && aligned;
  end
endmodule

// File: rtl/bfa_top.sv
module bfa_top
  import bfa_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mux_mode,
  input  logic [TS_W-1:0]        ts_offset,
  input  logic [BIT_W-1:0]       bit_offset,
  input  logic                   frame_pulse,
  input  logic                   ser_data,
  input  logic                   ser_sig,
  output logic [TS_W-1:0]        ts_idx,
  output logic [BIT_W-1:0]       bit_idx,
  output logic                   byte_valid,
  output logic [BITS_PER_TS-1:0] data_byte,
  output logic [BITS_PER_TS-1:0] sig_byte,
  output logic                   offset_change
);
  pos_t pos_eff;
  logic synced;
  logic last_bit;
  logic [1:0][BITS_PER_TS-1:0] lane_bytes;

  bfa_pos_counter u_cnt (
    .clk           (clk),
    .rst_n         (rst_n),
    .mux_mode      (mux_mode),
    .ts_offset     (ts_offset),
    .bit_offset    (bit_offset),
    .frame_pulse   (frame_pulse),
    .pos_eff       (pos_eff),
    .synced        (synced),
    .offset_change (offset_change)
  );

  assign last_bit = (pos_eff[BIT_W-1:0] == BIT_W'(BITS_PER_TS - 1));

  // Lane 0 carries payload, lane 1 carries signaling; same boundaries.
  bfa_byte_asm #(.LANES(2)) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_in     ({ser_sig, ser_data}),
    .last_bit   (last_bit),
    .aligned    (synced | frame_pulse),
    .bytes_out  (lane_bytes),
    .byte_valid (byte_valid)
  );

  assign data_byte = lane_bytes[0];
  assign sig_byte  = lane_bytes[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_idx  <= '0;
      bit_idx <= '0;
    end else begin
      ts_idx  <= pos_eff[POS_W-1:BIT_W];
      bit_idx <= pos_eff[BIT_W-1:0];
    end
  end

  p_strobe_last_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> (bit_idx == BIT_W'(BITS_PER_TS - 1)));

  p_strobe_after_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> synced);

  p_single_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mux_mode) |-> (ts_idx < TS_W'(SINGLE_TS)));
endmodule

// File: tb/bfa_top_tb_top.sv
module bfa_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mux_mode = 1'b0;
  logic [6:0] ts_offset = '0;
  logic [2:0] bit_offset = '0;
  logic frame_pulse = 1'b0;
  logic ser_data = 1'b0;
  logic ser_sig = 1'b0;
  logic [6:0] ts_idx;
  logic [2:0] bit_idx;
  logic byte_valid;
  logic [7:0] data_byte;
  logic [7:0] sig_byte;
  logic offset_change;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  bfa_top dut_i (
    .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode), .ts_offset(ts_offset),
    .bit_offset(bit_offset), .frame_pulse(frame_pulse), .ser_data(ser_data),
    .ser_sig(ser_sig), .ts_idx(ts_idx), .bit_idx(bit_idx),
    .byte_valid(byte_valid), .data_byte(data_byte), .sig_byte(sig_byte),
    .offset_change(offset_change)
  );

  function automatic logic [7:0] pay_of(input int ts);
    return 8'((ts * 37 + 5) & 255);
  endfunction

  function automatic logic [7:0] sig_of(input int ts);
    return 8'(((ts * 11) & 255) ^ 8'hA5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_case(input bit mux, input int ts, input int bo, input int p2);
    int len;
    int off;
    int base;
    int idx;
    int n;
    bit flag_exp;
    len = mux ? 1024 : 256;
    off = (mux ? ts : (ts % 32)) * 8 + bo;
    n = p2 + len + 20;
    @(posedge clk); #1;
    rst_n = 1'b0;
    frame_pulse = 1'b0;
    ser_data = 1'b0;
    ser_sig = 1'b0;
    mux_mode = mux;
    ts_offset = 7'(ts);
    bit_offset = 3'(bo);
    repeat (3) @(posedge clk);
    #1;
    chk(ts_idx == 0 && bit_idx == 0, "R1 idx", int'(ts_idx), 0);
    chk(!byte_valid && !offset_change, "R1 flags", int'({byte_valid, offset_change}), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #1;
      chk(!byte_valid, "R8 no strobe before pulse", int'(byte_valid), 0);
    end
    for (int k = 0; k < n; k++) begin
      frame_pulse = (k == 0) || (k == p2) || (k == p2 + len);
      base = (k >= p2) ? p2 : 0;
      idx = (((k - base - off) % len) + len) % len;
      ser_data = pay_of(idx / 8)[7 - (idx % 8)];
      ser_sig = sig_of(idx / 8)[7 - (idx % 8)];
      @(posedge clk); #1;
      if (mux)
        chk(int'(ts_idx) == idx / 8, "R4 R5 R10 ts_idx", int'(ts_idx), idx / 8);
      else if (ts >= 32)
        chk(int'(ts_idx) == idx / 8, "R3 ts_idx", int'(ts_idx), idx / 8);
      else
        chk(int'(ts_idx) == idx / 8, "R2 R5 R10 ts_idx", int'(ts_idx), idx / 8);
      chk(int'(bit_idx) == idx % 8, "R2 R4 bit_idx", int'(bit_idx), idx % 8);
      chk(byte_valid == (idx % 8 == 7), "R6 strobe", int'(byte_valid), int'(idx % 8 == 7));
      if (byte_valid && (k - base >= 7)) begin
        chk(data_byte == pay_of(idx / 8), "R6 data_byte", int'(data_byte), int'(pay_of(idx / 8)));
        chk(sig_byte == sig_of(idx / 8), "R7 sig_byte", int'(sig_byte), int'(sig_of(idx / 8)));
      end
      flag_exp = ((p2 % len) != 0) && (k >= p2);
      if (p2 % len == 0)
        chk(offset_change == flag_exp, "R8 R9 flag", int'(offset_change), int'(flag_exp));
      else
        chk(offset_change == flag_exp, "R10 R11 flag", int'(offset_change), int'(flag_exp));
    end
    frame_pulse = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", c_dummy(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic int c_dummy();
    return 150000;
  endfunction

  initial begin
    int ts_list[5] = '{0, 1, 5, 31, 45};
    int mts_list[3] = '{0, 77, 127};
    int mbo_list[3] = '{0, 3, 7};
    foreach (ts_list[i])
      for (int b = 0; b < 8; b++) run_case(1'b0, ts_list[i], b, 256);
    foreach (mts_list[i])
      foreach (mbo_list[j]) run_case(1'b1, mts_list[i], mbo_list[j], 1024);
    run_case(1'b0, 2, 1, 100);
    run_case(1'b1, 10, 6, 333);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule